// File: doc/BRIEF.md
# Dual-Source Divided Clock Generator

This block drives three divided clock outputs. Each output is derived from one of two source rates: a 32.768 kHz low-speed source or a high-speed source of roughly 4 MHz. Both sources enter as single-cycle enables (`slow_tick`, `fast_tick`) in one system clock domain, so every output is a registered level in that domain. Each channel owns an 8-bit control byte. The byte holds an enable, a power-of-two post-divide code, a source select and a pre-divide code. The pre-divide code counts only while the fast source is selected. Its top code gives the ratio 122, which is not a power of two. The control bytes sit at consecutive addresses 0, 1 and 2 behind a simple write port and a combinational read port.

Each channel runs a small state machine with five states. OFF holds the output low. SYNC waits for the first tick of the selected source. HIGH and LOW count source ticks for the two halves of a period. PULSE serves a total ratio of 1. The transitions are as follows:
- OFF to SYNC when the enable bit is seen. The channel copies the control byte as its active setting at this point.
- SYNC to HIGH on a source tick, or SYNC to PULSE on a source tick when the ratio is 1.
- HIGH to LOW after the high count is reached.
- LOW to HIGH, or LOW to PULSE, at the end of the period. This is the period boundary, and the active setting is copied again here.
- PULSE to HIGH at a tick when the new ratio is not 1.
- Any state to OFF as soon as the enable bit is clear.

Top module: `clkout_bank`

## Requirements
- R1: After reset, all three control bytes read as 0x00 and all outputs are low.
- R2: A write to address 0, 1 or 2 sets that channel's byte, which reads back unchanged. A write to address 3 changes nothing, and address 3 reads as 0x00.
- R3: Bit 0 is the enable. When it is clear in a channel's byte, that output is low from the first clock edge after the byte holds the cleared bit, and it stays low.
- R4: With bit 4 = 0, the slow source is selected and the total ratio N is 2^n, where n is bits 3:1. Bits 7:5 have no effect.
- R5: With bit 4 = 1, the fast source is selected and N = P * 2^n. P comes from bits 7:5: codes 0..6 give 1, 2, 4, 8, 16, 32, 64 and code 7 gives 122.
- R6: For N >= 2, each output period lasts N source ticks, and the output is high for floor(N/2) of those ticks.
- R7: For N = 1, the output is high for one system cycle following each selected source tick.
- R8: A new setting takes effect only at the next period boundary. A high phase under way keeps the length of the old setting.
- R9: The channels are independent. Settings and activity on one channel do not change another channel's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_tick | input | 1 | One-cycle enable at the low-speed source rate |
| fast_tick | input | 1 | One-cycle enable at the high-speed source rate |
| wr_en | input | 1 | Write strobe for the control bytes |
| wr_addr | input | 2 | Write address (channel index) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Control byte at rd_addr, or 0 for unmapped addresses |
| clk_out | output | 3 | Divided outputs, one bit per channel |

## Verification
A wrong tick count in HIGH or LOW shows up as a high time or a period that is off by whole source-tick intervals. This is visible within the first complete period after the new setting is latched. A boundary latch that happens too early cuts short the high pulse that is under way, so it is caught within that same pulse. A bad pre-divide entry, such as a power of two in place of 122, changes the measured period of the fast-source case. A decode fault between channels shows at once as a wrong readback or as activity on a channel that should not change.

// File: rtl/clkout_pkg.sv
package clkout_pkg;

    localparam int RATIO_W = 14;

    typedef struct packed {
        logic [2:0] pre;
        logic       fast;
        logic [2:0] post;
        logic       en;
    } ctrl_t;

    typedef enum logic [2:0] {
        PH_OFF,
        PH_SYNC,
        PH_HIGH,
        PH_LOW,
        PH_PULSE
    } phase_t;

    function automatic logic [RATIO_W-1:0] div_ratio(input ctrl_t c);
        logic [RATIO_W-1:0] base;
        if (!c.fast)
            base = RATIO_W'(1);
        else if (c.pre == 3'd7)
            base = RATIO_W'(122);
        else
            base = RATIO_W'(1) << c.pre;
        return base << c.post;
    endfunction

endpackage

// File: rtl/clkout_regs.sv
module clkout_regs
    import clkout_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output ctrl_t             ctrl_o [NUM_CH]
);

    ctrl_t ctrl_q [NUM_CH];

    for (genvar i = 0; i < NUM_CH; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ctrl_q[i] <= '0;
            else if (wr_en && int'(wr_addr) == i)
                ctrl_q[i] <= ctrl_t'(wr_data);
        end
        assign ctrl_o[i] = ctrl_q[i];
    end

    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < NUM_CH; i++)
            if (int'(rd_addr) == i)
                rd_data = ctrl_q[i];
    end

endmodule

// File: rtl/clkout_chan.sv
module clkout_chan
    import clkout_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   slow_tick,
    input  logic   fast_tick,
    input  ctrl_t  ctrl_i,
    output logic   out_o,
    output phase_t phase_o,
    output ctrl_t  act_o
);

    phase_t             state_q, state_d;
    ctrl_t              act_q, act_d;
    logic [RATIO_W-1:0] cnt_q, cnt_d;
    logic               pulse_q, pulse_d;

    logic               tick;
    logic [RATIO_W-1:0] ratio_cur, ratio_new, hi_len, lo_len;

    always_comb begin
        tick      = act_q.fast ? fast_tick : slow_tick;
        ratio_cur = div_ratio(act_q);
        ratio_new = div_ratio(ctrl_i);
        hi_len    = ratio_cur >> 1;
        lo_len    = ratio_cur - hi_len;
    end

    always_comb begin
        state_d = state_q;
        act_d   = act_q;
        cnt_d   = cnt_q;
        pulse_d = 1'b0;
        if (!ctrl_i.en) begin
            state_d = PH_OFF;
        end else begin
            unique case (state_q)
                PH_OFF: begin
                    act_d   = ctrl_i;
                    state_d = PH_SYNC;
                end
                PH_SYNC: begin
                    if (tick) begin
                        cnt_d = '0;
                        if (ratio_cur == RATIO_W'(1)) begin
                            state_d = PH_PULSE;
                            pulse_d = 1'b1;
                        end else begin
                            state_d = PH_HIGH;
                        end
                    end
                end
                PH_HIGH: begin
                    if (tick) begin
                        if (cnt_q == hi_len - RATIO_W'(1)) begin
                            state_d = PH_LOW;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q + RATIO_W'(1);
                        end
                    end
                end
                PH_LOW: begin
                    if (tick) begin
                        if (cnt_q == lo_len - RATIO_W'(1)) begin
                            act_d = ctrl_i;
                            cnt_d = '0;
                            if (ratio_new == RATIO_W'(1)) begin
                                state_d = PH_PULSE;
                                pulse_d = 1'b1;
                            end else begin
                                state_d = PH_HIGH;
                            end
                        end else begin
                            cnt_d = cnt_q + RATIO_W'(1);
                        end
                    end
                end
                PH_PULSE: begin
                    if (tick) begin
                        act_d = ctrl_i;
                        cnt_d = '0;
                        if (ratio_new == RATIO_W'(1))
                            pulse_d = 1'b1;
                        else
                            state_d = PH_HIGH;
                    end
                end
                default: state_d = PH_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_OFF;
            act_q   <= '0;
            cnt_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            state_q <= state_d;
            act_q   <= act_d;
            cnt_q   <= cnt_d;
            pulse_q <= pulse_d;
        end
    end

    always_comb begin
        out_o   = (state_q == PH_HIGH) || (state_q == PH_PULSE && pulse_q);
        phase_o = state_q;
        act_o   = act_q;
    end

endmodule

// File: rtl/clkout_bank.sv
module clkout_bank
    import clkout_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic              fast_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic [NUM_CH-1:0] clk_out
);

    ctrl_t  ctrl_w  [NUM_CH];
    phase_t phase_w [NUM_CH];
    ctrl_t  act_w   [NUM_CH];

    clkout_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .ctrl_o  (ctrl_w)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        clkout_chan chan_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .slow_tick (slow_tick),
            .fast_tick (fast_tick),
            .ctrl_i    (ctrl_w[i]),
            .out_o     (clk_out[i]),
            .phase_o   (phase_w[i]),
            .act_o     (act_w[i])
        );
    end

endmodule

// File: rtl/clkout_bank_chk.sv
module clkout_bank_chk
    import clkout_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [7:0]        wr_data,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [7:0]        rd_data,
    input logic [NUM_CH-1:0] clk_out,
    input ctrl_t             ctrl  [NUM_CH],
    input phase_t            phase [NUM_CH],
    input ctrl_t             act   [NUM_CH]
);

    assert_unmapped_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rd_addr) >= NUM_CH) |-> (rd_data == 8'h00));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        logic in_run;
        assign in_run = (phase[i] == PH_HIGH) || (phase[i] == PH_LOW);

        assert_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && int'(wr_addr) == i) |=> (ctrl[i] == ctrl_t'($past(wr_data))));

        assert_off_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!ctrl[i].en) |=> !clk_out[i]);

        assert_hold_setting_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (in_run && $past(in_run) &&
             !(phase[i] == PH_HIGH && $past(phase[i]) == PH_LOW)) |-> $stable(act[i]));
    end

endmodule

bind clkout_bank clkout_bank_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .clk_out (clk_out),
    .ctrl    (ctrl_w),
    .phase   (phase_w),
    .act     (act_w)
);

// File: tb/clkout_bank_tb_top.sv
module clkout_bank_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int SLOW_P     = 5;
    localparam int FAST_P     = 2;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slow_tick = 1'b0;
    logic       fast_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [2:0] clk_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkout_bank dut_i (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .fast_tick(fast_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .clk_out(clk_out)
    );

    initial begin
        int sc = 0;
        int fc = 0;
        forever begin
            @(negedge clk);
            sc = (sc + 1) % SLOW_P;
            fc = (fc + 1) % FAST_P;
            slow_tick = (sc == 0);
            fast_tick = (fc == 0);
        end
    end

    function automatic int exp_ratio(input logic [7:0] c);
        int pre = 1;
        if (c[4]) pre = (c[7:5] == 3'd7) ? 122 : (1 << c[7:5]);
        return pre << c[3:1];
    endfunction

    function automatic int exp_per(input logic [7:0] c);
        return exp_ratio(c) * (c[4] ? FAST_P : SLOW_P);
    endfunction

    function automatic int exp_hi(input logic [7:0] c);
        int n = exp_ratio(c);
        return (n == 1) ? 1 : (n / 2) * (c[4] ? FAST_P : SLOW_P);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_reg(input int a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_reg(input int a, output int v);
        rd_addr = 2'(a);
        #1;
        v = int'(rd_data);
    endtask

    task automatic wait_rise(input int ch);
        logic prev = clk_out[ch];
        forever begin
            @(negedge clk);
            if (clk_out[ch] && !prev) break;
            prev = clk_out[ch];
        end
    endtask

    task automatic measure(input int ch, output int hi, output int per);
        wait_rise(ch);
        hi = 0;
        while (clk_out[ch]) begin hi++; @(negedge clk); end
        per = hi;
        while (!clk_out[ch]) begin per++; @(negedge clk); end
    endtask

    task automatic run_case(input string req, input int ch, input logic [7:0] c);
        int hi, per;
        write_reg(ch, c);
        wait_rise(ch);
        wait_rise(ch);
        measure(ch, hi, per);
        check({req, " high"}, hi, exp_hi(c));
        check({req, " period"}, per, exp_per(c));
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int v, hi, per, seen, trial_ch;
        logic [7:0] c, c2;
        void'($urandom(32'd4711));

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 3; a++) begin
            read_reg(a, v);
            check("R1 reset byte", v, 0);
        end
        check("R1 outputs low", int'(clk_out), 0);

        // R2: readback and unmapped address
        write_reg(1, 8'hA4);
        read_reg(1, v); check("R2 readback ch1", v, 8'hA4);
        write_reg(3, 8'hFF);
        read_reg(3, v); check("R2 unmapped read", v, 0);
        for (int a = 0; a < 3; a++) begin
            read_reg(a, v);
            check("R2 unmapped write no effect", v, (a == 1) ? 8'hA4 : 0);
        end
        write_reg(1, 8'h00);

        // R4: slow source, pre code ignored
        run_case("R4 slow post1 pre7", 0, 8'b111_0_001_1);
        run_case("R4 slow post3", 0, 8'b000_0_011_1);
        // R7: ratio 1 on both sources
        run_case("R7 slow ratio1", 0, 8'b101_0_000_1);
        run_case("R7 fast ratio1", 0, 8'b000_1_000_1);
        // R5/R6: fast source, pre code 7 gives 122
        run_case("R5 fast pre7", 0, 8'b111_1_000_1);
        run_case("R6 fast pre2 post2", 0, 8'b010_1_010_1);

        // R8: change mid-high keeps the current pulse
        c  = 8'b000_0_011_1;
        c2 = 8'b000_0_000_1;
        run_case("R8 setup", 2, c);
        wait_rise(2);
        hi = 0;
        while (clk_out[2]) begin
            hi++;
            if (hi == 3) begin wr_en = 1'b1; wr_addr = 2'd2; wr_data = c2; end
            if (hi == 4) wr_en = 1'b0;
            @(negedge clk);
        end
        check("R8 pulse under way keeps length", hi, exp_hi(c));
        wait_rise(2); wait_rise(2);
        measure(2, hi, per);
        check("R8 new setting after boundary", per, exp_per(c2));

        // R3: disable holds the output low
        write_reg(2, 8'h00);
        @(negedge clk);
        seen = 0;
        for (int k = 0; k < 60; k++) begin
            if (clk_out[2]) seen++;
            @(negedge clk);
        end
        check("R3 disabled output low", seen, 0);

        // R9: channel 1 runs while channel 0 alters; channel 2 stays off
        run_case("R9 ch1 slow", 1, 8'b000_0_010_1);
        write_reg(0, 8'b001_1_001_1);
        measure(1, hi, per);
        check("R9 ch1 period unaffected", per, exp_per(8'b000_0_010_1));
        seen = 0;
        for (int k = 0; k < 40; k++) begin
            if (clk_out[2]) seen++;
            @(negedge clk);
        end
        check("R9 ch2 stays low", seen, 0);

        // Random settings across channels (R4, R5, R6, R7)
        for (int t = 0; t < 14; t++) begin
            trial_ch = $urandom_range(0, 2);
            c[0]   = 1'b1;
            c[4]   = 1'($urandom_range(0, 1));
            c[3:1] = c[4] ? 3'($urandom_range(0, 3)) : 3'($urandom_range(0, 7));
            c[7:5] = 3'($urandom_range(0, 7));
            run_case(c[4] ? "R5 random fast" : "R4 random slow", trial_ch, c);
            read_reg(trial_ch, v);
            check("R2 random readback", v, int'(c));
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule